// File: doc/BRIEF.md
# Descriptor-Chained Scatter-Gather DMA Engine

This block moves data between system memory and a storage device by walking a chain of region descriptors that software has placed in memory. Software loads the table location and direction, then sets the run bit. The engine reads one descriptor at a time over a single-beat read port and latches its base and length into private registers. It then grants the device an acknowledge and issues one memory beat for each device request, until the region is used up. At that point it reads the next descriptor, or it stops if the descriptor ends the chain.

A descriptor occupies two 32-bit words. The first word holds the region's byte base address. The second word holds the byte length in bits 15:0, where 0 stands for 65536, and the end-of-chain flag in bit 31. The table lives inside one 64 KB page. When the engine stops at the end of the chain, and also whenever the status interrupt bit becomes set, it emits a one-cycle buffer pulse. The pulse is a flush when data flows toward memory and an invalidate when data flows away from memory. Software watches three status outputs (active, error, interrupt).

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, the engine is idle with every status output low and no descriptor read, memory request, device acknowledge or buffer pulse.
- R2: A register write to offset 2 loads the table pointer with bits 1:0 forced to zero, takes the transfer direction from data bit 0 (1 = device to memory, shown on mem_we), and clears the error and interrupt bits.
- R3: A write to offset 0 with data bit 0 set, while the engine is idle, raises stat_active in the next cycle, and descriptor reading starts in that same cycle.
- R4: Descriptor k is read as two words, at pointer+8k and at pointer+8k+4. The address sum wraps inside the pointer's 64 KB page. The second word gives the length in bits 15:0 (0 means 65536 bytes) and the end-of-chain flag in bit 31.
- R5: dev_dack is high only after both words of a descriptor have been loaded. mem_req is high only while dev_dack and dev_dreq are both high. Each beat ends on mem_ack, moves 4 bytes, and raises mem_addr by 4, starting at the region base.
- R6: When the last beat of a region without the end-of-chain flag completes, the engine reads the next descriptor in the table.
- R7: When the last beat of a region with the end-of-chain flag completes, stat_active and dev_dack drop in the next cycle, so further device requests are ignored.
- R8: One cycle after a terminal stop, or after the interrupt bit goes from clear to set, exactly one of buf_flush (direction 1) or buf_inval (direction 0) pulses for one cycle.
- R9: A write to offset 0 with data bit 0 clear, while the engine is active, returns it to idle in the next cycle, with no further descriptor reads and no buffer pulse.
- R10: A high dev_intr sets stat_intr. Writing 1 to bit 2 at offset 1 clears it, but a set in the same cycle takes priority.
- R11: desc_err during a descriptor read, or mem_err during a memory request, sets stat_error and stops the engine. Writing 1 to bit 1 at offset 1 clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register offset: 0 command, 1 status, 2 table pointer |
| reg_wdata | input | 32 | Register write data |
| stat_active | output | 1 | Engine is running a chain |
| stat_error | output | 1 | Sticky error bit |
| stat_intr | output | 1 | Sticky interrupt bit |
| desc_req | output | 1 | Descriptor word read request |
| desc_addr | output | 32 | Descriptor word address |
| desc_ack | input | 1 | Descriptor read data valid |
| desc_rdata | input | 32 | Descriptor word |
| desc_err | input | 1 | Descriptor read failed |
| mem_req | output | 1 | Data beat request |
| mem_we | output | 1 | Beat writes memory (direction) |
| mem_addr | output | 32 | Data beat address |
| mem_ack | input | 1 | Data beat completed |
| mem_err | input | 1 | Data beat failed |
| dev_dreq | input | 1 | Device DMA request |
| dev_dack | output | 1 | DMA acknowledge to the device |
| dev_intr | input | 1 | Device interrupt |
| buf_flush | output | 1 | One-cycle buffer flush pulse |
| buf_inval | output | 1 | One-cycle buffer invalidate pulse |

## Verification
The assertions check, on every cycle, the rules that hold regardless of history. A memory beat is never requested without the device acknowledge. Descriptor reads and the acknowledge never overlap, and neither occurs while the engine is inactive. A flush and an invalidate never pulse together, and a pulse always matches the direction of the previous cycle. A device interrupt always leaves the interrupt bit set, and a new error always comes with a stopped engine. Only the bench scenarios can show the behaviour that depends on sequence: descriptor addresses and their wrap inside the page, the 65536-byte reading of a zero length, chaining to the next descriptor, the exact beat counts, and the timing of the terminal stop. The same applies to abort, to the error stops and to set-over-clear priority. The bench follows all of these with a behavioural model compared on every clock.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_PTR  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DESC0 = 2'd1,
        ST_DESC1 = 2'd2,
        ST_MOVE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sgd_regs.sv
module sgd_regs
    import sgd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              err_set,
    input  logic              intr_in,
    input  logic              term,
    output logic [ADDR_W-1:0] tbl_ptr,
    output logic              dir,
    output logic              err,
    output logic              intr,
    output logic              flush,
    output logic              inval
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              dir;
        logic              err;
        logic              intr;
        logic              flush;
        logic              inval;
    } regs_t;

    regs_t r_d, r_q;
    logic  intr_rise;
    logic  edge_evt;

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_sel == SEL_PTR) begin
            r_d.ptr  = {wr_data[ADDR_W-1:2], 2'b00};
            r_d.dir  = wr_data[0];
            r_d.err  = 1'b0;
            r_d.intr = 1'b0;
        end
        if (wr_en && wr_sel == SEL_STAT) begin
            if (wr_data[1]) r_d.err  = 1'b0;
            if (wr_data[2]) r_d.intr = 1'b0;
        end
        if (err_set) r_d.err  = 1'b1;
        if (intr_in) r_d.intr = 1'b1;
        intr_rise = r_d.intr & ~r_q.intr;
        edge_evt  = term | intr_rise;
        r_d.flush = r_q.dir & edge_evt;
        r_d.inval = ~r_q.dir & edge_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tbl_ptr = r_q.ptr;
    assign dir     = r_q.dir;
    assign err     = r_q.err;
    assign intr    = r_q.intr;
    assign flush   = r_q.flush;
    assign inval   = r_q.inval;
endmodule

// File: rtl/sgd_region.sv
module sgd_region #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              load_cnt,
    input  logic              beat,
    input  logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] cur_base,
    output logic              last_beat,
    output logic              eol
);
    localparam int unsigned REM_W = CNT_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [REM_W-1:0]  rem;
        logic              eol;
    } region_t;

    region_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (load_base) g_d.base = rdata;
        if (load_cnt) begin
            g_d.rem = (rdata[CNT_W-1:0] == '0) ? (REM_W'(1) << CNT_W)
                                               : {1'b0, rdata[CNT_W-1:0]};
            g_d.eol = rdata[ADDR_W-1];
        end
        if (beat) begin
            g_d.base = g_q.base + ADDR_W'(BEAT_BYTES);
            g_d.rem  = g_q.rem - REM_W'(BEAT_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign cur_base  = g_q.base;
    assign last_beat = (g_q.rem <= REM_W'(BEAT_BYTES));
    assign eol       = g_q.eol;
endmodule

// File: rtl/sgd_seq.sv
module sgd_seq
    import sgd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    input  logic [ADDR_W-1:0] tbl_ptr,
    input  logic              desc_ack,
    input  logic              desc_err,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              dreq,
    input  logic              last_beat,
    input  logic              eol,
    output logic              desc_req,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              load_base,
    output logic              load_cnt,
    output logic              beat,
    output logic              dack,
    output logic              mem_req,
    output logic              err_set,
    output logic              term,
    output logic              active
);
    localparam int unsigned IDX_W = PAGE_W - 3;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t             s_d, s_q;
    logic [PAGE_W-1:0] off;

    always_comb begin
        s_d       = s_q;
        err_set   = 1'b0;
        term      = 1'b0;
        load_base = 1'b0;
        load_cnt  = 1'b0;
        beat      = 1'b0;
        desc_req  = (s_q.st == ST_DESC0) || (s_q.st == ST_DESC1);
        dack      = (s_q.st == ST_MOVE);
        mem_req   = dack & dreq;
        case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    s_d.st  = ST_DESC0;
                    s_d.idx = '0;
                end
            end
            ST_DESC0: begin
                if (desc_err) begin
                    s_d.st  = ST_IDLE;
                    err_set = 1'b1;
                end else if (desc_ack) begin
                    load_base = 1'b1;
                    s_d.st    = ST_DESC1;
                end
            end
            ST_DESC1: begin
                if (desc_err) begin
                    s_d.st  = ST_IDLE;
                    err_set = 1'b1;
                end else if (desc_ack) begin
                    load_cnt = 1'b1;
                    s_d.st   = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (mem_req && mem_err) begin
                    s_d.st  = ST_IDLE;
                    err_set = 1'b1;
                end else if (mem_req && mem_ack) begin
                    beat = 1'b1;
                    if (last_beat) begin
                        if (eol) begin
                            term   = 1'b1;
                            s_d.st = ST_IDLE;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                            s_d.st  = ST_DESC0;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (halt && s_q.st != ST_IDLE) begin
            s_d.st  = ST_IDLE;
            err_set = 1'b0;
            term    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.idx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        off       = {s_q.idx, 3'b000} | ((s_q.st == ST_DESC1) ? PAGE_W'(4) : '0);
        desc_addr = {tbl_ptr[ADDR_W-1:PAGE_W], tbl_ptr[PAGE_W-1:0] + off};
    end

    assign active = (s_q.st != ST_IDLE);
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sgd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned PAGE_W     = 16,
    parameter int unsigned BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              stat_active,
    output logic              stat_error,
    output logic              stat_intr,
    output logic              desc_req,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic              desc_ack,
    input  logic [ADDR_W-1:0] desc_rdata,
    input  logic              desc_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              dev_dreq,
    output logic              dev_dack,
    input  logic              dev_intr,
    output logic              buf_flush,
    output logic              buf_inval
);
    logic              go, halt;
    logic              err_set, term;
    logic              load_base, load_cnt, beat;
    logic              last_beat, eol;
    logic              xfer_dir;
    logic [ADDR_W-1:0] tbl_ptr;

    assign go   = reg_wr && (reg_sel == SEL_CMD) &&  reg_wdata[0];
    assign halt = reg_wr && (reg_sel == SEL_CMD) && !reg_wdata[0];

    sgd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .err_set (err_set),
        .intr_in (dev_intr),
        .term    (term),
        .tbl_ptr (tbl_ptr),
        .dir     (xfer_dir),
        .err     (stat_error),
        .intr    (stat_intr),
        .flush   (buf_flush),
        .inval   (buf_inval)
    );

    sgd_region #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (load_base),
        .load_cnt  (load_cnt),
        .beat      (beat),
        .rdata     (desc_rdata),
        .cur_base  (mem_addr),
        .last_beat (last_beat),
        .eol       (eol)
    );

    sgd_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .halt      (halt),
        .tbl_ptr   (tbl_ptr),
        .desc_ack  (desc_ack),
        .desc_err  (desc_err),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .dreq      (dev_dreq),
        .last_beat (last_beat),
        .eol       (eol),
        .desc_req  (desc_req),
        .desc_addr (desc_addr),
        .load_base (load_base),
        .load_cnt  (load_cnt),
        .beat      (beat),
        .dack      (dev_dack),
        .mem_req   (mem_req),
        .err_set   (err_set),
        .term      (term),
        .active    (stat_active)
    );

    assign mem_we = xfer_dir;
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic dev_dack,
    input logic desc_req,
    input logic stat_active,
    input logic stat_error,
    input logic stat_intr,
    input logic dev_intr,
    input logic buf_flush,
    input logic buf_inval,
    input logic xfer_dir
);
    a_r5_req_needs_dack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> dev_dack);

    a_r5_no_fetch_during_dack: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req && dev_dack));

    a_r7_bus_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req || dev_dack) |-> stat_active);

    a_r8_single_pulse_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_flush && buf_inval));

    a_r8_flush_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        buf_flush |-> $past(xfer_dir));

    a_r10_intr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dev_intr |=> stat_intr);

    a_r11_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_error) |-> !stat_active);
endmodule

bind sg_dma_engine sgd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .dev_dack    (dev_dack),
    .desc_req    (desc_req),
    .stat_active (stat_active),
    .stat_error  (stat_error),
    .stat_intr   (stat_intr),
    .dev_intr    (dev_intr),
    .buf_flush   (buf_flush),
    .buf_inval   (buf_inval),
    .xfer_dir    (xfer_dir)
);

// File: tb/sim_sg_dma_engine.sv
module sim_sg_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        stat_active, stat_error, stat_intr;
    logic        desc_req;
    logic [31:0] desc_addr;
    logic        desc_ack;
    logic [31:0] desc_rdata;
    logic        desc_err;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic        mem_ack, mem_err;
    logic        dev_dreq, dev_dack, dev_intr;
    logic        buf_flush, buf_inval;

    always #5 clk = ~clk;

    sg_dma_engine u0 (.*);

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int          m_st;
    int          m_idx;
    int          m_rem;
    logic [31:0] m_ptr, m_base;
    logic        m_dir, m_err, m_intr, m_flush, m_inval, m_eol;

    logic [31:0] tbl [logic [31:0]];
    logic [15:0] lfsr = 16'hACE1;
    bit          throttle;
    int          cnt_fetch, cnt_beat, cnt_flush, cnt_inval;
    logic [31:0] first_daddr;
    bit          saw_wrap;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_daddr();
        logic [15:0] o;
        o = 16'(m_idx * 8) + ((m_st == 2) ? 16'd4 : 16'd0);
        return {m_ptr[31:16], m_ptr[15:0] + o};
    endfunction

    task automatic step();
        int          nst, nidx, nrem;
        logic [31:0] nptr, nbase;
        logic        ndir, nerr, nintr, neol, eset, tm, rise, go, halt;
        nst = m_st; nidx = m_idx; nrem = m_rem; nptr = m_ptr; nbase = m_base;
        ndir = m_dir; nerr = m_err; nintr = m_intr; neol = m_eol;
        eset = 0; tm = 0;
        go   = reg_wr && reg_sel == 2'd0 &&  reg_wdata[0];
        halt = reg_wr && reg_sel == 2'd0 && !reg_wdata[0];
        case (m_st)
            0: if (go) begin nst = 1; nidx = 0; end
            1: if (desc_err) begin nst = 0; eset = 1; end
               else if (desc_ack) begin nbase = desc_rdata; nst = 2; end
            2: if (desc_err) begin nst = 0; eset = 1; end
               else if (desc_ack) begin
                   nrem = (desc_rdata[15:0] == 0) ? 65536 : int'(desc_rdata[15:0]);
                   neol = desc_rdata[31];
                   nst  = 3;
               end
            default: if (dev_dreq) begin
                if (mem_err) begin nst = 0; eset = 1; end
                else if (mem_ack) begin
                    nbase = m_base + 4;
                    if (m_rem <= 4) begin
                        if (m_eol) begin tm = 1; nst = 0; end
                        else begin nidx = (m_idx + 1) % 8192; nst = 1; end
                    end else nrem = m_rem - 4;
                end
            end
        endcase
        if (halt && m_st != 0) begin nst = 0; eset = 0; tm = 0; end
        if (reg_wr && reg_sel == 2'd2) begin
            nptr = reg_wdata & 32'hFFFF_FFFC; ndir = reg_wdata[0]; nerr = 0; nintr = 0;
        end
        if (reg_wr && reg_sel == 2'd1) begin
            if (reg_wdata[1]) nerr = 0;
            if (reg_wdata[2]) nintr = 0;
        end
        if (eset) nerr = 1;
        if (dev_intr) nintr = 1;
        rise = nintr && !m_intr;
        @(posedge clk);
        m_flush = m_dir && (tm || rise);
        m_inval = !m_dir && (tm || rise);
        m_st = nst; m_idx = nidx; m_rem = nrem; m_ptr = nptr; m_base = nbase;
        m_dir = ndir; m_err = nerr; m_intr = nintr; m_eol = neol;
        @(negedge clk);
        chk(stat_active === (m_st != 0), "R7", "stat_active", 32'(stat_active), 32'(m_st != 0));
        chk(stat_error === m_err, "R11", "stat_error", 32'(stat_error), 32'(m_err));
        chk(stat_intr === m_intr, "R10", "stat_intr", 32'(stat_intr), 32'(m_intr));
        chk(desc_req === (m_st == 1 || m_st == 2), "R3", "desc_req", 32'(desc_req), 32'(m_st == 1 || m_st == 2));
        if (m_st == 1 || m_st == 2)
            chk(desc_addr === m_daddr(), "R4", "desc_addr", desc_addr, m_daddr());
        chk(dev_dack === (m_st == 3), "R5", "dev_dack", 32'(dev_dack), 32'(m_st == 3));
        chk(mem_req === (m_st == 3 && dev_dreq), "R5", "mem_req", 32'(mem_req), 32'(m_st == 3 && dev_dreq));
        if (m_st == 3 && dev_dreq)
            chk(mem_addr === m_base, "R5", "mem_addr", mem_addr, m_base);
        chk(mem_we === m_dir, "R2", "mem_we", 32'(mem_we), 32'(m_dir));
        chk(buf_flush === m_flush, "R8", "buf_flush", 32'(buf_flush), 32'(m_flush));
        chk(buf_inval === m_inval, "R8", "buf_inval", 32'(buf_inval), 32'(m_inval));
        if (buf_flush) cnt_flush++;
        if (buf_inval) cnt_inval++;
    endtask

    task automatic cycle();
        logic [31:0] a;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (throttle) begin
            desc_ack = lfsr[0];
            mem_ack  = lfsr[1] | lfsr[2];
            dev_dreq = lfsr[3] | lfsr[5];
        end else begin
            desc_ack = 1'b1; mem_ack = 1'b1; dev_dreq = 1'b1;
        end
        a = m_daddr();
        desc_rdata = tbl.exists(a) ? tbl[a] : 32'h0;
        #1;
        if (desc_req && desc_ack && !desc_err) begin
            if (cnt_fetch == 0) first_daddr = desc_addr;
            if (desc_addr == 32'h0002_0000) saw_wrap = 1;
            cnt_fetch++;
        end
        if (mem_req && mem_ack && !mem_err) cnt_beat++;
        step();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        cycle();
        reg_wr = 1'b0;
    endtask

    task automatic run_idle(input int limit);
        for (int i = 0; i < limit && m_st != 0; i++) cycle();
    endtask

    task automatic clr_counts();
        cnt_fetch = 0; cnt_beat = 0; cnt_flush = 0; cnt_inval = 0; saw_wrap = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        desc_ack = 0; desc_rdata = 0; desc_err = 0;
        mem_ack = 0; mem_err = 0; dev_dreq = 0; dev_intr = 0;
        m_st = 0; m_idx = 0; m_rem = 0; m_ptr = 0; m_base = 0;
        m_dir = 0; m_err = 0; m_intr = 0; m_flush = 0; m_inval = 0; m_eol = 0;
        throttle = 0;
        clr_counts();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!stat_active && !stat_error && !stat_intr, "R1", "status", {29'd0, stat_active, stat_error, stat_intr}, 0);
        chk(!desc_req && !mem_req && !dev_dack, "R1", "bus", {29'd0, desc_req, mem_req, dev_dack}, 0);
        chk(!buf_flush && !buf_inval, "R1", "pulses", {30'd0, buf_flush, buf_inval}, 0);
        rst_n = 1;

        // Chain of three regions, direction to memory, throttled
        tbl[32'h0001_0000] = 32'h1000_0000; tbl[32'h0001_0004] = 32'h0000_0008;
        tbl[32'h0001_0008] = 32'h2000_0000; tbl[32'h0001_000C] = 32'h0000_000C;
        tbl[32'h0001_0010] = 32'h3000_0000; tbl[32'h0001_0014] = 32'h8000_0004;
        wr(2'd2, 32'h0001_0003);
        chk(mem_we === 1'b1, "R2", "direction bit", 32'(mem_we), 1);
        clr_counts();
        wr(2'd0, 32'h1);
        chk(stat_active && desc_req, "R3", "start", {30'd0, stat_active, desc_req}, 3);
        throttle = 1;
        run_idle(3000);
        throttle = 0;
        cycle(); cycle();
        chk(first_daddr == 32'h0001_0000, "R2", "pointer low bits", first_daddr, 32'h0001_0000);
        chk(cnt_fetch == 6, "R6", "descriptor words read", cnt_fetch, 6);
        chk(cnt_beat == 6, "R5", "beats", cnt_beat, 6);
        chk(cnt_flush == 1 && cnt_inval == 0, "R8", "flush count", cnt_flush, 1);
        chk(!stat_active && !dev_dack, "R7", "stopped", {30'd0, stat_active, dev_dack}, 0);

        // Zero length means 65536 bytes, direction from memory
        tbl[32'h0003_0000] = 32'h4000_0000; tbl[32'h0003_0004] = 32'h8000_0000;
        wr(2'd2, 32'h0003_0000);
        clr_counts();
        wr(2'd0, 32'h1);
        run_idle(20000);
        cycle();
        chk(cnt_beat == 16384, "R4", "zero length beats", cnt_beat, 16384);
        chk(cnt_inval == 1 && cnt_flush == 0, "R8", "invalidate count", cnt_inval, 1);

        // Abort mid-region
        tbl[32'h0004_0000] = 32'h5000_0000; tbl[32'h0004_0004] = 32'h0000_0100;
        wr(2'd2, 32'h0004_0001);
        wr(2'd0, 32'h1);
        repeat (8) cycle();
        chk(dev_dack === 1'b1, "R9", "in transfer before abort", 32'(dev_dack), 1);
        wr(2'd0, 32'h0);
        clr_counts();
        repeat (10) cycle();
        chk(cnt_fetch == 0 && !stat_active, "R9", "after abort", cnt_fetch, 0);
        chk(cnt_flush == 0 && cnt_inval == 0, "R9", "no pulse", cnt_flush + cnt_inval, 0);

        // Descriptor read error
        wr(2'd2, 32'h0005_0000);
        wr(2'd0, 32'h1);
        desc_err = 1; cycle(); desc_err = 0;
        chk(stat_error && !stat_active, "R11", "desc error", {30'd0, stat_error, stat_active}, 2);
        wr(2'd1, 32'h2);
        chk(!stat_error, "R11", "error cleared", 32'(stat_error), 0);

        // Memory error
        tbl[32'h0006_0000] = 32'h6000_0000; tbl[32'h0006_0004] = 32'h8000_0040;
        wr(2'd2, 32'h0006_0001);
        wr(2'd0, 32'h1);
        repeat (3) cycle();
        mem_err = 1; cycle(); mem_err = 0;
        chk(stat_error && !stat_active, "R11", "mem error", {30'd0, stat_error, stat_active}, 2);
        wr(2'd2, 32'h0006_0001);
        chk(!stat_error, "R2", "pointer write clears error", 32'(stat_error), 0);

        // Device interrupt during a transfer
        clr_counts();
        wr(2'd0, 32'h1);
        repeat (4) cycle();
        dev_intr = 1; cycle(); dev_intr = 0;
        chk(stat_intr === 1'b1, "R10", "intr set", 32'(stat_intr), 1);
        chk(cnt_flush == 1, "R8", "flush on intr", cnt_flush, 1);
        dev_intr = 1; wr(2'd1, 32'h4); dev_intr = 0;
        chk(stat_intr === 1'b1, "R10", "set wins over clear", 32'(stat_intr), 1);
        wr(2'd1, 32'h4);
        chk(stat_intr === 1'b0, "R10", "intr cleared", 32'(stat_intr), 0);
        run_idle(200);

        // Table wrapping inside its page
        tbl[32'h0002_FFF0] = 32'h7000_0000; tbl[32'h0002_FFF4] = 32'h0000_0004;
        tbl[32'h0002_FFF8] = 32'h7100_0000; tbl[32'h0002_FFFC] = 32'h0000_0004;
        tbl[32'h0002_0000] = 32'h7200_0000; tbl[32'h0002_0004] = 32'h8000_0008;
        wr(2'd2, 32'h0002_FFF0);
        clr_counts();
        wr(2'd0, 32'h1);
        run_idle(200);
        cycle();
        chk(saw_wrap, "R4", "page wrap", 32'(saw_wrap), 1);
        chk(cnt_fetch == 6, "R6", "wrap chain words", cnt_fetch, 6);
        chk(cnt_beat == 4, "R5", "wrap chain beats", cnt_beat, 4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule